// File: doc/BRIEF.md
# Dual-Role Port Mode Switch Controller

This block sequences a dual-role USB port between an idle role, a host role and a device role as software commands it. Commands arrive as a six-bit write with a one-cycle strobe. The block reports whether it is usable yet (`not_ready`) and which role is live (`host_ready`, `dev_ready`). It also publishes a six-bit state word that carries a host-side state code and a device-side state code.

Leaving a role is not instant. A deselect write puts the controller into a settle wait, and no role can come back until that wait has run out. The wait lasts one second in normal operation. When the `sim_fast` bit is set at the moment of the deselect, it lasts a few milliseconds instead. A role request written during the wait is held and takes effect as soon as the wait ends. Bus power sensing is reduced to a single `vbus_ok` input, which gates device readiness.

Top module: `usb_role_fsm`

## Requirements
- R1: While reset is held and on the first cycle after it, `not_ready` is 1, `host_ready` and `dev_ready` are 0 and `state_word` is 0.
- R2: `not_ready` falls RDY_CYCLES clock edges after reset is released. Every command written while it is 1 is ignored.
- R3: In idle, a write with bit 0 set (host select) makes the host role live on the next cycle: host code 1 and `host_ready` = 1. If bit 0 and bit 1 are set in the same write, host wins.
- R4: In idle, a write with only bit 1 set (device select) moves to device code 1 (waiting for bus power). With `vbus_ok` = 1 the controller goes to device code 2 with `dev_ready` = 1. If `vbus_ok` falls, it returns to device code 1.
- R5: A deselect is a single write with bits 5:2 all set. A write with only some of those bits set is ignored. While a role is live or waiting, select bits are ignored.
- R6: A deselect enters the settle wait on the next cycle, and both ready outputs drop. During the wait, host code is 2 if the host role was left; otherwise device code is 3.
- R7: The settle wait lasts SLOW_MS*CLK_PER_MS cycles if `sim_fast` was 0 at the deselect write, and FAST_MS*CLK_PER_MS cycles if it was 1. Later changes to `sim_fast` do not alter a wait already in progress.
- R8: Select requests written during the wait, including one sampled on its final cycle, are applied on the cycle after the wait ends. Host has priority over device. With no request the controller returns to idle (code 0/0).
- R9: `host_ready` and `dev_ready` are never both 1. `host_ready` rises only from idle or at the end of a settle wait.
- R10: `state_word[5:3]` holds the host code (0 idle, 1 live, 2 settling) and `state_word[2:0]` holds the device code (0 idle, 1 waiting for power, 2 live, 3 settling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle write strobe for `cmd` |
| cmd | input | 6 | Command bits: 0 host select, 1 device select, 2 host bus drop, 3 device bus drop, 4 host power off, 5 device power off |
| sim_fast | input | 1 | Selects the short settle interval |
| vbus_ok | input | 1 | Bus power present |
| not_ready | output | 1 | Controller not yet usable after reset |
| host_ready | output | 1 | Host role live |
| dev_ready | output | 1 | Device role live |
| state_word | output | 6 | Host code in bits 5:3, device code in bits 2:0 |

## Verification
The hardest situations to reach are at the edges of the settle wait. One is a request that arrives exactly on the last counted cycle. The other is a `sim_fast` change that lands partway through a long wait. The bench issues the deselect on a known negative edge and counts cycles from that point. It then drives the request on the negative edge just before the final wait edge, and flips `sim_fast` a few cycles into a one-second wait. The bench uses a small cycles-per-millisecond value, so the one-second wait stays short enough to run to completion and both interval lengths are checked to the exact cycle.

// File: rtl/usb_role_fsm.sv
module usb_role_fsm #(
  parameter int CLK_PER_MS = 125000,
  parameter int SLOW_MS    = 1000,
  parameter int FAST_MS    = 2,
  parameter int RDY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [5:0] cmd,
  input  logic       sim_fast,
  input  logic       vbus_ok,
  output logic       not_ready,
  output logic       host_ready,
  output logic       dev_ready,
  output logic [5:0] state_word
);
  localparam int SLOW_N = SLOW_MS * CLK_PER_MS;
  localparam int FAST_N = FAST_MS * CLK_PER_MS;
  localparam int CW = $clog2(SLOW_N + 1);
  localparam int RW = $clog2(RDY_CYCLES + 1);
  localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_N - 1);
  localparam logic [CW-1:0] FAST_LD = CW'(FAST_N - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_N);

  typedef enum logic [2:0] {S_IDLE, S_HOST, S_DWAIT, S_DEV, S_SETTLE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rdy_cnt;
  logic          from_host, settle_fast, pend_h, pend_d;
  logic          wr, req_h, req_d, desel;
  logic [2:0]    host_code, dev_code;

  assign wr    = cmd_valid && !not_ready;
  assign req_h = wr && cmd[0];
  assign req_d = wr && cmd[1];
  assign desel = wr && (&cmd[5:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      not_ready <= 1'b1;
      rdy_cnt   <= '0;
    end else if (not_ready) begin
      if (rdy_cnt == RW'(RDY_CYCLES - 1)) not_ready <= 1'b0;
      else rdy_cnt <= rdy_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      from_host   <= 1'b0;
      settle_fast <= 1'b0;
      pend_h      <= 1'b0;
      pend_d      <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (req_h) state <= S_HOST;
          else if (req_d) state <= S_DWAIT;
        S_HOST, S_DWAIT, S_DEV:
          if (desel) begin
            state       <= S_SETTLE;
            from_host   <= (state == S_HOST);
            settle_fast <= sim_fast;
            cnt         <= sim_fast ? FAST_LD : SLOW_LD;
            pend_h      <= 1'b0;
            pend_d      <= 1'b0;
          end else if (state == S_DWAIT && vbus_ok) state <= S_DEV;
          else if (state == S_DEV && !vbus_ok) state <= S_DWAIT;
        S_SETTLE:
          if (cnt == '0) begin
            if (pend_h || req_h) state <= S_HOST;
            else if (pend_d || req_d) state <= S_DWAIT;
            else state <= S_IDLE;
            pend_h <= 1'b0;
            pend_d <= 1'b0;
          end else begin
            cnt    <= cnt - 1'b1;
            pend_h <= pend_h | req_h;
            pend_d <= pend_d | req_d;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_ready = (state == S_HOST);
  assign dev_ready  = (state == S_DEV);

  always_comb begin
    host_code = 3'd0;
    dev_code  = 3'd0;
    case (state)
      S_HOST:   host_code = 3'd1;
      S_DWAIT:  dev_code  = 3'd1;
      S_DEV:    dev_code  = 3'd2;
      S_SETTLE: if (from_host) host_code = 3'd2; else dev_code = 3'd3;
      default:  ;
    endcase
  end

  assign state_word = {host_code, dev_code};

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ready && dev_ready)); // R9
  AST_NRDY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready |-> state == S_IDLE); // R2
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE && cnt != '0) |=> state == S_SETTLE); // R7
  AST_FAST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE && settle_fast) |-> cnt < FAST_LIM); // R7
  AST_HOST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> ($past(state) == S_IDLE ||
                           ($past(state) == S_SETTLE && $past(cnt) == '0))); // R9
endmodule

// File: tb/usb_role_fsm_bench.sv
module usb_role_fsm_bench;
  localparam int CPM = 10, SLOW = 1000, FAST = 2, RDY = 8;
  localparam int NS = SLOW * CPM, NF = FAST * CPM;
  localparam logic [5:0] HOST = 6'b000001, DEV = 6'b000010, BOTH = 6'b000011;
  localparam logic [5:0] DESEL = 6'b111100, PART = 6'b000100;

  logic clk = 0, rst_n = 0, cmd_valid = 0, sim_fast = 0, vbus_ok = 0;
  logic [5:0] cmd = 0;
  logic not_ready, host_ready, dev_ready;
  logic [5:0] state_word;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int at; logic [5:0] word; logic hr, dr, nr; string tag; } exp_t;
  exp_t q[$];

  usb_role_fsm #(.CLK_PER_MS(CPM), .SLOW_MS(SLOW), .FAST_MS(FAST), .RDY_CYCLES(RDY)) u_usb_role_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .sim_fast(sim_fast),
    .vbus_ok(vbus_ok), .not_ready(not_ready), .host_ready(host_ready),
    .dev_ready(dev_ready), .state_word(state_word));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, logic [5:0] w, logic hr, logic dr, logic nr, string tag);
    exp_t e;
    e.at = cyc + dly; e.word = w; e.hr = hr; e.dr = dr; e.nr = nr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(logic [5:0] c);
    cmd_valid = 1; cmd = c;
    @(negedge clk);
    cmd_valid = 0; cmd = 0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: check missed at cycle %0d, expected cycle %0d", e.tag, cyc, e.at);
      end else if ({state_word, host_ready, dev_ready, not_ready} != {e.word, e.hr, e.dr, e.nr}) begin
        fails++;
        $display("FAIL %s: cycle %0d word=%b hr=%b dr=%b nr=%b, expected word=%b hr=%b dr=%b nr=%b",
                 e.tag, cyc, state_word, host_ready, dev_ready, not_ready, e.word, e.hr, e.dr, e.nr);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_at(1, 6'd0, 0, 0, 1, "R1 reset state");
    tick(1);
    rst_n = 1;
    expect_at(1, 6'd0, 0, 0, 1, "R1/R2 host write ignored while not ready");
    expect_at(RDY - 1, 6'd0, 0, 0, 1, "R2 not_ready still set");
    expect_at(RDY, 6'd0, 0, 0, 0, "R2 not_ready cleared");
    send(HOST);
    tick(RDY);
    // R3 host select from idle
    expect_at(1, 6'b001000, 1, 0, 0, "R3 host live");
    send(HOST);
    expect_at(1, 6'b001000, 1, 0, 0, "R5 device select ignored while host live");
    send(DEV);
    expect_at(1, 6'b001000, 1, 0, 0, "R5 partial deselect ignored");
    send(PART);
    // fast settle with host request
    sim_fast = 1;
    expect_at(1, 6'b010000, 0, 0, 0, "R6 host settle code");
    expect_at(NF, 6'b010000, 0, 0, 0, "R7 fast wait last cycle");
    expect_at(NF + 1, 6'b001000, 1, 0, 0, "R8 latched host applied");
    send(DESEL);
    tick(3);
    send(HOST);
    tick(NF - 4);
    tick(1);
    // slow settle, sim_fast flipped mid-wait, both requested
    sim_fast = 0;
    expect_at(1, 6'b010000, 0, 0, 0, "R6 slow settle entry");
    expect_at(NS, 6'b010000, 0, 0, 0, "R7 slow wait last cycle");
    expect_at(NS + 1, 6'b001000, 1, 0, 0, "R8 host wins over device");
    send(DESEL);
    tick(2);
    sim_fast = 1;
    send(BOTH);
    tick(NS - 3);
    tick(1);
    // settle with no request returns to idle
    expect_at(1, 6'b010000, 0, 0, 0, "R6 settle entry");
    expect_at(NF + 1, 6'd0, 0, 0, 0, "R8 idle after empty wait");
    send(DESEL);
    tick(NF);
    tick(1);
    // device path, R4
    vbus_ok = 0;
    expect_at(1, 6'b000001, 0, 0, 0, "R4 device waiting for power");
    send(DEV);
    vbus_ok = 1;
    expect_at(1, 6'b000010, 0, 1, 0, "R4 device live");
    tick(1);
    vbus_ok = 0;
    expect_at(1, 6'b000001, 0, 0, 0, "R4 power loss");
    tick(1);
    vbus_ok = 1;
    expect_at(1, 6'b000010, 0, 1, 0, "R4 power back R9");
    tick(1);
    // device settle with device request
    expect_at(1, 6'b000011, 0, 0, 0, "R6 device settle code R10");
    expect_at(NF, 6'b000011, 0, 0, 0, "R7 device fast wait last cycle");
    expect_at(NF + 1, 6'b000001, 0, 0, 0, "R8 latched device applied");
    expect_at(NF + 2, 6'b000010, 0, 1, 0, "R4 device live after wait");
    send(DESEL);
    tick(1);
    send(DEV);
    tick(NF - 1);
    tick(1);
    // request on final wait cycle
    expect_at(NF, 6'b000011, 0, 0, 0, "R7 final cycle still settling");
    expect_at(NF + 1, 6'b001000, 1, 0, 0, "R8 final-cycle host request applied");
    send(DESEL);
    tick(NF - 1);
    send(HOST);
    tick(2);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R8: %0d expectations left unchecked, expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule